// File: doc/BRIEF.md
# Gated Post-Divider Clock Channel

This block turns a fast reference clock into a one-cycle clock-enable pulse that recurs every N reference cycles. N is the product of an 8-bit programmable divider and a fixed post-divider chosen at build time (1 or 2). A programmed divider of zero stands for the largest value the field can hold, which is 255.

Two independent conditions turn the pulse off. The first is a disable bit in the channel's own control word. The second is a hold bit in a control word shared with other channels; a per-instance mask picks out this channel's hold bit. Software loads the control word through a simple write strobe and can read the word back. On reset the word takes a per-instance default value.

A new divider value waits for the current period to finish before it takes effect, so no period is ever shortened. When the channel leaves the gated state, counting restarts from zero, so the first pulse lands exactly N cycles after the enable.

Top module: `post_div_channel`

## Requirements
- R1: After reset, `ctrl_q` equals the per-instance reset value (default 0x104: disabled, divider 4) and `out_pulse` is low.
- R2: While bit 8 of the control word (the disable bit) is 1, `out_pulse` stays low.
- R3: While any bit of `hold_word` selected by `HOLD_MASK` (default 0x04) is 1, `out_pulse` stays low. Bits of `hold_word` outside the mask have no effect on the pulse period.
- R4: A divider field (bits 7:0) of 0 gives the same ratio as 255, that is 255 × `POST_DIV` (510 with the default `POST_DIV` of 2).
- R5: While the channel is ungated, `out_pulse` is high for exactly one cycle in every `div × POST_DIV` cycles.
- R6: A divider written in the middle of a period takes effect only after that period's pulse. The pulse ending the current period keeps the old spacing.
- R7: When the channel becomes ungated (an enabling write, or the hold being released), the first pulse occurs in the N-th cycle after the ungating, where the ungated cycle itself is cycle 1.
- R8: A write with `cfg_we` high loads `cfg_wdata` into the control word, and the new value is visible on `ctrl_q` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word: bit 8 disables the channel, bits 7:0 hold the divider |
| hold_word | input | 8 | Shared hold control word |
| ctrl_q | output | 9 | Current control word |
| out_pulse | output | 1 | Divided clock-enable pulse |

## Verification
The hardest case to reach from the ports is a divider write that lands mid-period. The bench waits for a pulse and issues the write on that same half-cycle. From there it counts the cycles to the next pulse, which must keep the old spacing, and then measures the gap after that, which must use the new spacing. It also drives hold bits outside the mask while measuring the period, to show they have no effect. Finally it releases the hold on a sampling edge so that the restart alignment can be counted from that exact cycle.

// File: rtl/post_div_pkg.sv
package post_div_pkg;

    localparam int unsigned DEF_DIV_W  = 8;
    localparam int unsigned DEF_HOLD_W = 8;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } run_e;

    function automatic int unsigned eff_ratio(int unsigned div, int unsigned div_w,
                                              int unsigned post);
        int unsigned d;
        d = (div == 0) ? ((1 << div_w) - 1) : div;
        return d * post;
    endfunction

    function automatic int unsigned max_ratio(int unsigned div_w, int unsigned post);
        return ((1 << div_w) - 1) * post;
    endfunction

endpackage

// File: rtl/chan_ctrl_reg.sv
module chan_ctrl_reg #(
    parameter int unsigned      CTRL_W    = 9,
    parameter logic [CTRL_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RESET_VAL;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/chan_gate.sv
module chan_gate #(
    parameter int unsigned       HOLD_W    = 8,
    parameter logic [HOLD_W-1:0] HOLD_MASK = '0
) (
    input  logic              disable_bit,
    input  logic [HOLD_W-1:0] hold_word,
    output logic              active
);
    logic held;
    assign held   = |(hold_word & HOLD_MASK);
    assign active = !disable_bit && !held;
endmodule

// File: rtl/chan_counter.sv
module chan_counter
    import post_div_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] new_ratio,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    run_e             state;
    logic [CNT_W-1:0] cur_ratio;
    logic [CNT_W-1:0] eff;
    logic             last;

    // Until the first ungated cycle has passed, the incoming ratio applies.
    assign eff   = (state == CH_RUN) ? cur_ratio : new_ratio;
    assign last  = (count == (eff - ONE));
    assign pulse = active && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CH_IDLE;
            count     <= '0;
            cur_ratio <= '0;
        end else if (!active) begin
            state <= CH_IDLE;
            count <= '0;
        end else begin
            state <= CH_RUN;
            count <= last ? '0 : count + ONE;
            if (state == CH_IDLE || last)
                cur_ratio <= new_ratio;
        end
    end
endmodule

// File: rtl/post_div_channel.sv
module post_div_channel
    import post_div_pkg::*;
#(
    parameter int unsigned       DIV_W      = DEF_DIV_W,
    parameter int unsigned       POST_DIV   = 2,
    parameter int unsigned       HOLD_W     = DEF_HOLD_W,
    parameter logic [HOLD_W-1:0] HOLD_MASK  = 8'h04,
    parameter logic [DIV_W:0]    RESET_CTRL = 9'h104
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DIV_W:0]    cfg_wdata,
    input  logic [HOLD_W-1:0] hold_word,
    output logic [DIV_W:0]    ctrl_q,
    output logic              out_pulse
);
    localparam int unsigned CTRL_W  = DIV_W + 1;
    localparam int unsigned DIS_BIT = DIV_W;
    localparam int unsigned MAX_R   = max_ratio(DIV_W, POST_DIV);
    localparam int unsigned CNT_W   = $clog2(MAX_R + 1);

    logic             chan_active;
    logic [CNT_W-1:0] chan_count;
    logic [CNT_W-1:0] new_ratio;

    chan_ctrl_reg #(
        .CTRL_W    (CTRL_W),
        .RESET_VAL (RESET_CTRL)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (ctrl_q)
    );

    chan_gate #(
        .HOLD_W    (HOLD_W),
        .HOLD_MASK (HOLD_MASK)
    ) u_gate (
        .disable_bit (ctrl_q[DIS_BIT]),
        .hold_word   (hold_word),
        .active      (chan_active)
    );

    assign new_ratio = CNT_W'(eff_ratio(32'(ctrl_q[DIV_W-1:0]), DIV_W, POST_DIV));

    chan_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .active    (chan_active),
        .new_ratio (new_ratio),
        .pulse     (out_pulse),
        .count     (chan_count)
    );
endmodule

// File: rtl/post_div_channel_chk.sv
module post_div_channel_chk #(
    parameter int unsigned       DIV_W      = 8,
    parameter int unsigned       HOLD_W     = 8,
    parameter logic [HOLD_W-1:0] HOLD_MASK  = 8'h04,
    parameter logic [DIV_W:0]    RESET_CTRL = 9'h104,
    parameter int unsigned       CNT_W      = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [DIV_W:0]    cfg_wdata,
    input logic [HOLD_W-1:0] hold_word,
    input logic [DIV_W:0]    ctrl_q,
    input logic              out_pulse,
    input logic              active,
    input logic [CNT_W-1:0]  count
);
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(cfg_we)) |-> (ctrl_q == RESET_CTRL));

    assert_disable_gates_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[DIV_W] |-> !out_pulse);

    assert_hold_gates_R3: assert property (@(posedge clk) disable iff (rst)
        (|(hold_word & HOLD_MASK)) |-> !out_pulse);

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !$past(active)) |-> (count == '0));

    assert_write_load_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (ctrl_q == $past(cfg_wdata)));
endmodule

bind post_div_channel post_div_channel_chk #(
    .DIV_W      (DIV_W),
    .HOLD_W     (HOLD_W),
    .HOLD_MASK  (HOLD_MASK),
    .RESET_CTRL (RESET_CTRL),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .hold_word (hold_word),
    .ctrl_q    (ctrl_q),
    .out_pulse (out_pulse),
    .active    (chan_active),
    .count     (chan_count)
);

// File: tb/post_div_channel_bench.sv
`timescale 1ns/1ps
module post_div_channel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic [7:0] hold_word = '0;
    logic [8:0] ctrl_q;
    logic       out_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    localparam int POST = 2;

    post_div_channel u_post_div_channel (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .hold_word (hold_word),
        .ctrl_q    (ctrl_q),
        .out_pulse (out_pulse)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the word loaded.
    task automatic write_ctrl(input logic [8:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic steps_to_pulse(output int n);
        n = 0;
        while (!out_pulse && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic gap(output int n);
        n = 1;
        @(negedge clk);
        while (!out_pulse && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_pulses(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_pulse) c++;
        end
    endtask

    task automatic t_reset();
        int c;
        check(ctrl_q == 9'h104, "R1 reset ctrl", ctrl_q, 9'h104);
        check(out_pulse == 1'b0, "R1 reset pulse", out_pulse, 0);
        count_pulses(40, c);
        check(c == 0, "R2 disabled after reset", c, 0);
    endtask

    task automatic t_ratio(input logic [7:0] div, input int exp_r, input string req);
        int n;
        write_ctrl({1'b1, div});
        write_ctrl({1'b0, div});
        check(ctrl_q == {1'b0, div}, "R8 readback", ctrl_q, {1'b0, div});
        steps_to_pulse(n);
        check(n == exp_r - 1, {req, " R7 first pulse"}, n, exp_r - 1);
        gap(n);
        check(n == exp_r, {req, " R5 period"}, n, exp_r);
        if (exp_r > 1) begin
            @(negedge clk);
            check(out_pulse == 1'b0, {req, " R5 one-cycle width"}, out_pulse, 0);
        end
    endtask

    task automatic t_change();
        int n;
        t_ratio(8'd4, 4 * POST, "R6 setup");
        steps_to_pulse(n);
        write_ctrl(9'h00A);
        steps_to_pulse(n);
        check(n == 4 * POST - 1, "R6 old period kept", n, 4 * POST - 1);
        gap(n);
        check(n == 10 * POST, "R6 new period", n, 10 * POST);
    endtask

    task automatic t_disable();
        int c;
        write_ctrl(9'h103);
        check(ctrl_q == 9'h103, "R8 readback disable", ctrl_q, 9'h103);
        count_pulses(600, c);
        check(c == 0, "R2 disabled", c, 0);
    endtask

    task automatic t_hold();
        int n, c;
        t_ratio(8'd2, 2 * POST, "R3 setup");
        hold_word = 8'hFB;
        steps_to_pulse(n);
        gap(n);
        check(n == 2 * POST, "R3 unmasked hold ignored", n, 2 * POST);
        hold_word = 8'h04;
        count_pulses(600, c);
        check(c == 0, "R3 masked hold", c, 0);
        hold_word = 8'h00;
        steps_to_pulse(n);
        check(n == 2 * POST - 1, "R7 restart after hold", n, 2 * POST - 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratio(8'd3, 3 * POST, "R5 div3");
        t_ratio(8'd1, 1 * POST, "R5 div1");
        t_ratio(8'd0, 255 * POST, "R4 div0");
        t_ratio(8'd255, 255 * POST, "R4 div255");
        t_change();
        t_disable();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule